// File: doc/BRIEF.md
# Dual-Channel SAR Converter Readout Controller

This block sits on the host side of a converter with two successive-approximation cores that sample at the same instant. It drives the converter's chip select, serial clock, 3-bit input address, input-mode line and range line. It collects one 12-bit result from each core per frame. With two data lines, both results arrive in parallel. With one data line, core A's result comes first and core B's follows in a frame of double length.

The converter latches the address, mode and range lines when chip select falls. Those settings only govern the following conversion. The controller therefore remembers the configuration it drove in the previous frame and tags each result with it. It also derives the output coding from that configuration. Straight-binary results are offset and two's-complement results are sign-extended, so every result leaves as a 13-bit signed value.

Requests arrive as a valid pulse that carries a configuration. One request can wait in a holding slot while a frame is running. A request for an address that does not exist is refused and an error pulse is raised.

Top module: `sar_pair_reader`

## Requirements
- R1: After reset, `cs_n` is high, `sclk` is low, `res_valid` and `req_err` are low and `req_ready` is high. The converter is assumed to be set for address 0, single-ended, narrow range.
- R2: `req_ready` is high exactly when the holding slot is empty. A request accepted while a frame is running is held, and its frame starts only after the running frame and its quiet time have finished.
- R3: A request with address 6 or 7 raises `req_err` for one cycle, one clock after it is presented. It is not stored and starts no frame. Valid requests leave `req_err` low.
- R4: `adc_addr`, `adc_single` and `adc_wide` carry the accepted request's values at least one clock before `cs_n` falls. They stay unchanged while `cs_n` is low. Frames start in request order.
- R5: `sclk` is low whenever `cs_n` is high. A frame has 14 `sclk` rising edges when `one_line` is 0 and 28 when it is 1. Each `sclk` phase lasts DIV clocks.
- R6: Data bits are taken on `sclk` rising edges. The result is the 12 bits of rising edges 3 to 14, MSB first; edges 1 and 2 are leading zeros. With two lines, A comes from `sdo_a` and B from `sdo_b`.
- R7: With `one_line` = 1, A is rising edges 3–14 and B is rising edges 17–28, both on `sdo_a`. `sdo_b` is ignored.
- R8: `cs_n` stays high for at least QUIET clocks between frames.
- R9: Each result is tagged (`res_chan`, `res_single`, `res_wide`) with the configuration driven at the previous frame's chip-select fall. The first frame after reset uses the R1 configuration.
- R10: `res_twos` = 1 (two's complement) for differential with address bit 0 = 0, or single-ended with the wide range. Otherwise it is 0 (straight binary, which covers pseudo-differential and single-ended narrow).
- R11: With SIGNED_OUT = 1, a two's-complement result is the 12-bit code sign-extended to 13 bits. A straight-binary result is the code minus 2048.
- R12: `res_valid` is a one-clock pulse, raised one clock after `cs_n` returns high at the end of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Conversion request strobe |
| req_chan | input | 3 | Requested input address |
| req_single | input | 1 | 1 = single-ended, 0 = pair mode |
| req_wide | input | 1 | 1 = 0..2×VREF range, 0 = 0..VREF |
| req_ready | output | 1 | Holding slot is free |
| req_err | output | 1 | Pulse: request refused (bad address) |
| one_line | input | 1 | 1 = both results on `sdo_a` |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Converter serial clock |
| adc_addr | output | 3 | Address lines to converter |
| adc_single | output | 1 | Input-mode line to converter |
| adc_wide | output | 1 | Range line to converter |
| sdo_a | input | 1 | Serial data, core A (or both) |
| sdo_b | input | 1 | Serial data, core B |
| res_valid | output | 1 | Result strobe |
| res_a | output | 13 | Core A result, signed |
| res_b | output | 13 | Core B result, signed |
| res_chan | output | 3 | Address used for this result |
| res_single | output | 1 | Mode used for this result |
| res_wide | output | 1 | Range used for this result |
| res_twos | output | 1 | Coding tag, 1 = two's complement |

## Verification
The converter model returns all-zero, all-one, mid-scale and mid-scale-minus-one codes, then a spread of other codes. These separate a wrong offset from a wrong sign extension, and show bits landing in the wrong position. The configuration changes every frame and walks through every mode and range mix, so a tag taken from the current frame rather than the previous one cannot match. Runs with two lines and with one line separate the two capture windows, and a nonzero pattern on `sdo_b` in one-line runs shows whether that line is ignored. Back-to-back requests and refused addresses check the holding slot and the error path.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
  typedef struct packed {
    logic [2:0] chan;
    logic       single;
    logic       wide;
  } sar_cfg_t;

  localparam sar_cfg_t CFG_RESET = '{chan: 3'd0, single: 1'b1, wide: 1'b0};

  function automatic logic uses_twos(input sar_cfg_t c);
    if (c.single) return c.wide;
    return ~c.chan[0];
  endfunction
endpackage

// File: rtl/sar_rd_reqslot.sv
module sar_rd_reqslot
  import sar_rd_pkg::*;
#(
  parameter int NUM_IN = 6
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     req_valid,
  input  sar_cfg_t req_cfg,
  output logic     req_ready,
  output logic     err,
  input  logic     take,
  output logic     pend_valid,
  output sar_cfg_t pend_cfg
);
  logic bad;
  assign bad       = int'(req_cfg.chan) >= NUM_IN;
  assign req_ready = ~pend_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_cfg   <= CFG_RESET;
      err        <= 1'b0;
    end else begin
      err <= req_valid & ~pend_valid & bad;
      if (take) pend_valid <= 1'b0;
      if (req_valid && !pend_valid && !bad) begin
        pend_valid <= 1'b1;
        pend_cfg   <= req_cfg;
      end
    end
  end

  // R3: refused request raises error and stays out of the slot
  p_reject_r3: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && bad |=> err && !pend_valid);

  // R2: a held request survives until the sequencer takes it
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    pend_valid && !take |=> pend_valid && $stable(pend_cfg));
endmodule

// File: rtl/sar_rd_sequencer.sv
module sar_rd_sequencer
  import sar_rd_pkg::*;
#(
  parameter int DIV   = 2,
  parameter int QUIET = 3,
  parameter int RES_W = 12,
  parameter int LEAD  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pend_valid,
  input  sar_cfg_t         pend_cfg,
  input  logic             one_line,
  input  logic             sdo_a,
  input  logic             sdo_b,
  output logic             take,
  output logic             cs_n,
  output logic             sclk,
  output sar_cfg_t         pin_cfg,
  output logic             frame_start,
  output logic             frame_done,
  output logic [RES_W-1:0] sh_a,
  output logic [RES_W-1:0] sh_b
);
  localparam int FRAME1 = LEAD + RES_W;
  localparam int FRAME2 = 2 * FRAME1;
  localparam int CW     = $clog2(FRAME2 + 1);
  localparam int DW     = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int QW     = (QUIET > 1) ? $clog2(QUIET) : 1;
  localparam logic [CW-1:0] N_SHORT = CW'(FRAME1);
  localparam logic [CW-1:0] N_LONG  = CW'(FRAME2);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_RUN, S_QUIET} st_t;
  st_t           st;
  logic [DW-1:0] div_cnt;
  logic [CW-1:0] edges;
  logic [QW-1:0] q_cnt;
  logic          long_q;
  logic [CW-1:0] n_clk;
  logic          win_a, win_b, bit_b;

  assign take  = (st == S_IDLE) && pend_valid;
  assign n_clk = long_q ? N_LONG : N_SHORT;
  // capture windows, by 0-based rising-edge index
  assign win_a = (edges >= CW'(LEAD)) && (edges < N_SHORT);
  assign win_b = long_q ? (edges >= CW'(FRAME1 + LEAD)) : win_a;
  assign bit_b = long_q ? sdo_a : sdo_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      cs_n        <= 1'b1;
      sclk        <= 1'b0;
      div_cnt     <= '0;
      edges       <= '0;
      q_cnt       <= '0;
      long_q      <= 1'b0;
      pin_cfg     <= CFG_RESET;
      frame_start <= 1'b0;
      frame_done  <= 1'b0;
      sh_a        <= '0;
      sh_b        <= '0;
    end else begin
      frame_start <= 1'b0;
      frame_done  <= 1'b0;
      case (st)
        S_IDLE: if (pend_valid) begin
          pin_cfg <= pend_cfg;
          long_q  <= one_line;
          st      <= S_SETUP;
        end
        S_SETUP: begin
          cs_n        <= 1'b0;
          frame_start <= 1'b1;
          div_cnt     <= '0;
          edges       <= '0;
          sh_a        <= '0;
          sh_b        <= '0;
          st          <= S_RUN;
        end
        S_RUN: begin
          if (div_cnt == DW'(DIV - 1)) begin
            div_cnt <= '0;
            if (!sclk) begin
              sclk  <= 1'b1;
              edges <= edges + 1'b1;
              if (win_a) sh_a <= {sh_a[RES_W-2:0], sdo_a};
              if (win_b) sh_b <= {sh_b[RES_W-2:0], bit_b};
            end else begin
              sclk <= 1'b0;
              if (edges == n_clk) begin
                cs_n       <= 1'b1;
                frame_done <= 1'b1;
                q_cnt      <= '0;
                st         <= S_QUIET;
              end
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        default: begin
          if (q_cnt == QW'(QUIET - 1)) st <= S_IDLE;
          else q_cnt <= q_cnt + 1'b1;
        end
      endcase
    end
  end

  // independent counters for the frame checks
  logic          sclk_d;
  logic [CW-1:0] rise_cnt;
  logic [31:0]   hi_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b0;
      rise_cnt <= '0;
      hi_cnt   <= 32'(QUIET);
    end else begin
      sclk_d <= sclk;
      if (cs_n) rise_cnt <= '0;
      else if (sclk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
      if (!cs_n) hi_cnt <= '0;
      else if (hi_cnt < 32'(QUIET)) hi_cnt <= hi_cnt + 1;
    end
  end

  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  p_edge_count_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> rise_cnt == n_clk);

  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> hi_cnt >= 32'(QUIET));

  p_pins_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !cs_n && $past(!cs_n) |-> $stable(pin_cfg));
endmodule

// File: rtl/sar_rd_format.sv
module sar_rd_format
  import sar_rd_pkg::*;
#(
  parameter int RES_W      = 12,
  parameter bit SIGNED_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           frame_start,
  input  logic           frame_done,
  input  sar_cfg_t       pin_cfg,
  input  logic [RES_W-1:0] raw_a,
  input  logic [RES_W-1:0] raw_b,
  output logic           res_valid,
  output logic [RES_W:0] res_a,
  output logic [RES_W:0] res_b,
  output sar_cfg_t       res_cfg,
  output logic           res_twos
);
  sar_cfg_t       armed, cur_tag;
  logic           twos;
  logic [RES_W:0] fa, fb;

  assign twos = uses_twos(cur_tag);

  generate
    if (SIGNED_OUT) begin : g_signed
      assign fa = twos ? {raw_a[RES_W-1], raw_a}
                       : {~raw_a[RES_W-1], ~raw_a[RES_W-1], raw_a[RES_W-2:0]};
      assign fb = twos ? {raw_b[RES_W-1], raw_b}
                       : {~raw_b[RES_W-1], ~raw_b[RES_W-1], raw_b[RES_W-2:0]};
    end else begin : g_raw
      assign fa = {1'b0, raw_a};
      assign fb = {1'b0, raw_b};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= CFG_RESET;
      cur_tag   <= CFG_RESET;
      res_valid <= 1'b0;
      res_a     <= '0;
      res_b     <= '0;
      res_cfg   <= CFG_RESET;
      res_twos  <= 1'b0;
    end else begin
      res_valid <= frame_done;
      if (frame_start) begin
        cur_tag <= armed;
        armed   <= pin_cfg;
      end
      if (frame_done) begin
        res_a    <= fa;
        res_b    <= fb;
        res_cfg  <= cur_tag;
        res_twos <= twos;
      end
    end
  end

  // R10: fully differential tags are always two's complement
  p_diff_twos_r10: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_cfg.single && !res_cfg.chan[0] |-> res_twos);
endmodule

// File: rtl/sar_pair_reader.sv
module sar_pair_reader
  import sar_rd_pkg::*;
#(
  parameter int DIV        = 2,
  parameter int QUIET      = 3,
  parameter int RES_W      = 12,
  parameter int LEAD       = 2,
  parameter int NUM_IN     = 6,
  parameter bit SIGNED_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [2:0]     req_chan,
  input  logic           req_single,
  input  logic           req_wide,
  output logic           req_ready,
  output logic           req_err,
  input  logic           one_line,
  output logic           cs_n,
  output logic           sclk,
  output logic [2:0]     adc_addr,
  output logic           adc_single,
  output logic           adc_wide,
  input  logic           sdo_a,
  input  logic           sdo_b,
  output logic           res_valid,
  output logic [RES_W:0] res_a,
  output logic [RES_W:0] res_b,
  output logic [2:0]     res_chan,
  output logic           res_single,
  output logic           res_wide,
  output logic           res_twos
);
  sar_cfg_t         req_cfg, pend_cfg, pin_cfg, res_cfg;
  logic             pend_valid, take, frame_start, frame_done;
  logic [RES_W-1:0] sh_a, sh_b;

  assign req_cfg = '{chan: req_chan, single: req_single, wide: req_wide};

  sar_rd_reqslot #(.NUM_IN(NUM_IN)) u_slot (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cfg(req_cfg),
    .req_ready(req_ready), .err(req_err), .take(take),
    .pend_valid(pend_valid), .pend_cfg(pend_cfg)
  );

  sar_rd_sequencer #(.DIV(DIV), .QUIET(QUIET), .RES_W(RES_W), .LEAD(LEAD)) u_seq (
    .clk(clk), .rst(rst), .pend_valid(pend_valid), .pend_cfg(pend_cfg),
    .one_line(one_line), .sdo_a(sdo_a), .sdo_b(sdo_b), .take(take),
    .cs_n(cs_n), .sclk(sclk), .pin_cfg(pin_cfg),
    .frame_start(frame_start), .frame_done(frame_done),
    .sh_a(sh_a), .sh_b(sh_b)
  );

  sar_rd_format #(.RES_W(RES_W), .SIGNED_OUT(SIGNED_OUT)) u_fmt (
    .clk(clk), .rst(rst), .frame_start(frame_start), .frame_done(frame_done),
    .pin_cfg(pin_cfg), .raw_a(sh_a), .raw_b(sh_b),
    .res_valid(res_valid), .res_a(res_a), .res_b(res_b),
    .res_cfg(res_cfg), .res_twos(res_twos)
  );

  assign adc_addr   = pin_cfg.chan;
  assign adc_single = pin_cfg.single;
  assign adc_wide   = pin_cfg.wide;
  assign res_chan   = res_cfg.chan;
  assign res_single = res_cfg.single;
  assign res_wide   = res_cfg.wide;

  p_valid_after_cs_r12: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> cs_n && $past(cs_n) && !$past(cs_n, 2));

  p_valid_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
endmodule

// File: tb/sar_pair_reader_test.sv
module sar_pair_reader_test;
  localparam int DIV   = 2;
  localparam int QUIET = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_chan = '0;
  logic        req_single = 1'b0;
  logic        req_wide = 1'b0;
  logic        req_ready, req_err;
  logic        one_line = 1'b0;
  logic        cs_n, sclk, adc_single, adc_wide;
  logic [2:0]  adc_addr;
  logic        sdo_a = 1'b0;
  logic        sdo_b = 1'b0;
  logic        res_valid, res_single, res_wide, res_twos;
  logic [12:0] res_a, res_b;
  logic [2:0]  res_chan;

  always #5 clk = ~clk;

  sar_pair_reader #(.DIV(DIV), .QUIET(QUIET)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
    .req_single(req_single), .req_wide(req_wide), .req_ready(req_ready),
    .req_err(req_err), .one_line(one_line), .cs_n(cs_n), .sclk(sclk),
    .adc_addr(adc_addr), .adc_single(adc_single), .adc_wide(adc_wide),
    .sdo_a(sdo_a), .sdo_b(sdo_b), .res_valid(res_valid), .res_a(res_a),
    .res_b(res_b), .res_chan(res_chan), .res_single(res_single),
    .res_wide(res_wide), .res_twos(res_twos)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  logic [4:0]  req_q[$];   // {chan, single, wide} of accepted requests
  logic [29:0] exp_q[$];   // {long, used cfg(5), codeA, codeB}
  logic [4:0]  m_prev = {3'd0, 1'b1, 1'b0};  // R1 assumed power-up setting
  logic [27:0] shA, shB;
  int          fidx = 0;
  bit          m_long = 1'b0;

  function automatic logic [11:0] gen_code(input int idx, input bit b);
    if (idx == 1) return b ? 12'hFFF : 12'h000;
    if (idx == 2) return b ? 12'h7FF : 12'h800;
    if (b) return 12'((idx * 2741 + 3000) % 4096);
    return 12'((idx * 1237 + 5) % 4096);
  endfunction

  always @(negedge cs_n) begin
    logic [11:0] ca, cb;
    logic [4:0]  pins;
    fidx++;
    ca = gen_code(fidx, 1'b0);
    cb = gen_code(fidx, 1'b1);
    pins = {adc_addr, adc_single, adc_wide};
    if (req_q.size() == 0) chk(1'b0, "R4 frame without request", int'(pins), -1);
    else begin
      logic [4:0] want;
      want = req_q.pop_front();
      chk(pins == want, "R4/R2 pins at chip-select fall", int'(pins), int'(want));
    end
    m_long = one_line;
    exp_q.push_back({m_long, m_prev, ca, cb});
    m_prev = pins;
    if (m_long) begin
      shA = {2'b00, ca, 2'b00, cb};
      shB = 28'hAAAAAAA;
    end else begin
      shA = {2'b00, ca, 14'h0};
      shB = {2'b00, cb, 14'h0};
    end
    sdo_a = shA[27];
    sdo_b = shB[27];
  end

  always @(negedge sclk) begin
    if (cs_n === 1'b0) begin
      shA = shA << 1;
      shB = shB << 1;
      sdo_a = shA[27];
      sdo_b = shB[27];
    end
  end

  // ---------------- per-clock reference comparison ----------------
  function automatic int expv(input logic [11:0] raw, input bit tw);
    if (tw) return (int'(raw) >= 2048) ? int'(raw) - 4096 : int'(raw);
    return int'(raw) - 2048;
  endfunction

  logic prev_cs = 1'b1, prev2_cs = 1'b1, prev_sclk = 1'b0;
  int   hi_cnt = 100;
  int   rises = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (cs_n && sclk) chk(1'b0, "R5 sclk high while idle", 1, 0);
      if (!cs_n && prev_cs) begin
        chk(hi_cnt >= QUIET, "R8 quiet time", hi_cnt, QUIET);
        hi_cnt = 0;
        rises = 0;
      end
      if (cs_n && !prev_cs)
        chk(rises == (m_long ? 28 : 14), "R5 sclk edges per frame", rises, m_long ? 28 : 14);
      if (cs_n) hi_cnt++;
      if (!cs_n && sclk && !prev_sclk) rises++;
      if (res_valid) begin
        logic [29:0] e;
        logic [4:0]  used;
        bit          tw;
        chk(cs_n && prev_cs && !prev2_cs, "R12 strobe timing", int'({prev2_cs, prev_cs, cs_n}), 3);
        if (exp_q.size() == 0) chk(1'b0, "R12 unexpected result", 1, 0);
        else begin
          e = exp_q.pop_front();
          used = e[28:24];
          tw = used[1] ? used[0] : ~used[2];
          chk(res_chan == used[4:2], "R9 channel tag", int'(res_chan), int'(used[4:2]));
          chk({res_single, res_wide} == used[1:0], "R9 mode/range tag",
              int'({res_single, res_wide}), int'(used[1:0]));
          chk(res_twos == tw, "R10 coding tag", int'(res_twos), int'(tw));
          chk(int'($signed(res_a)) == expv(e[23:12], tw),
              e[29] ? "R7 one-line result A" : "R6/R11 result A",
              int'($signed(res_a)), expv(e[23:12], tw));
          chk(int'($signed(res_b)) == expv(e[11:0], tw),
              e[29] ? "R7 one-line result B" : "R6/R11 result B",
              int'($signed(res_b)), expv(e[11:0], tw));
        end
      end
    end
    prev2_cs  = prev_cs;
    prev_cs   = cs_n;
    prev_sclk = sclk;
  end

  // ---------------- stimulus ----------------
  task automatic send(input int ch, input bit sg, input bit wd);
    bit bad;
    bad = (ch > 5);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid  = 1'b1;
    req_chan   = ch[2:0];
    req_single = sg;
    req_wide   = wd;
    if (!bad) req_q.push_back({ch[2:0], sg, wd});
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_err == bad, "R3 error flag", int'(req_err), int'(bad));
  endtask

  task automatic settle();
    repeat (300) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n after reset", int'(cs_n), 1);
    chk(sclk == 1'b0, "R1 sclk after reset", int'(sclk), 0);
    chk(res_valid == 1'b0, "R1 res_valid after reset", int'(res_valid), 0);
    chk(req_err == 1'b0, "R1 req_err after reset", int'(req_err), 0);
    chk(req_ready == 1'b1, "R1 req_ready after reset", int'(req_ready), 1);

    // two-line frames through every mode/range mix
    send(1, 1'b1, 1'b0);
    send(2, 1'b0, 1'b0);
    send(3, 1'b0, 1'b1);
    send(4, 1'b1, 1'b1);
    send(5, 1'b0, 1'b0);
    send(0, 1'b0, 1'b1);
    send(5, 1'b1, 1'b0);
    settle();

    // R3: refused addresses start nothing and leave the slot empty
    send(6, 1'b1, 1'b0);
    send(7, 1'b0, 1'b1);
    @(negedge clk);
    chk(req_ready == 1'b1, "R3 slot empty after refusal", int'(req_ready), 1);
    repeat (20) @(negedge clk);
    chk(cs_n == 1'b1, "R3 no frame after refusal", int'(cs_n), 1);

    // R2: second request held while the first frame runs
    send(2, 1'b1, 1'b1);
    send(1, 1'b0, 1'b0);
    chk(req_ready == 1'b0, "R2 request held during frame", int'(req_ready), 0);
    chk(cs_n == 1'b0, "R2 first frame running", int'(cs_n), 0);
    settle();

    // R7: single data line
    one_line = 1'b1;
    send(3, 1'b1, 1'b0);
    send(0, 1'b1, 1'b1);
    send(4, 1'b0, 1'b1);
    send(1, 1'b0, 1'b1);
    settle();
    one_line = 1'b0;
    send(2, 1'b1, 1'b0);
    send(5, 1'b1, 1'b1);
    settle();

    chk(req_q.size() == 0, "R4 all requests framed", req_q.size(), 0);
    chk(exp_q.size() == 0, "R9 all results delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule